// File: doc/BRIEF.md
# Load-reserved / store-conditional unit

This block carries out the two halves of a lock-free update sequence for a single hardware thread. A load-reserved instruction reads memory and records the 8-byte granule it touched. A later store-conditional writes memory only when that record is still intact. The unit decodes the 32-bit atomic-format instruction word. It takes the register operand values from the issuing pipeline and drives a one-request-at-a-time memory port. It returns a value for the destination register. Word and doubleword widths are supported, and loaded words are sign-extended to 64 bits.

Writes by other agents are reported on a snoop input. A snoop write that lands in the recorded granule cancels the record. No bus locking is involved: the record is only a tracker, and the memory port stays free for every other agent. The ordering bits of the instruction are forwarded unchanged with the memory request so the downstream fabric can honour them.

The instruction word is split, from bit 31 down, into: funct5[31:27], aq[26], rl[25], rs2[24:20], rs1[19:15], funct3[14:12], rd[11:7], opcode[6:0]. The rs1 and rs2 values arrive on their own ports.

Top module: `lrsc_unit`

## Requirements
- R1: An instruction is legal only when all of the following hold: opcode is 0101111, funct3 is 010 (word) or 011 (doubleword), and funct5 is either 00010 (load-reserved, with the rs2 field equal to 00000) or 00011 (store-conditional). Any other word produces a result with `res_ill`=1 and `res_data`=0 one cycle after acceptance, and makes no memory request.
- R2: A load-reserved reads from the address in `rs1_val`. For a word it returns `mem_rdata[31:0]` sign-extended to 64 bits; for a doubleword it returns all 64 bits. The result appears in the cycle after the memory response.
- R3: A load-reserved records a valid reservation for the 8-byte granule `rs1_val[63:3]`, replacing any reservation held before.
- R4: A store-conditional whose address lies in the reserved granule of a valid reservation issues a write request (`mem_we`=1) with `rs2_val` (word: low 32 bits, upper bits zero) and returns 0 in `res_data` after the response.
- R5: A store-conditional without a matching valid reservation issues no memory request and returns exactly 1 in `res_data` one cycle after acceptance.
- R6: Every store-conditional clears the reservation, whether it succeeds or fails.
- R7: A snoop write (`snoop_valid`) whose address falls in the reserved granule clears the reservation. When it arrives in the same cycle as a store-conditional is accepted, the store-conditional fails. A snoop to another granule has no effect.
- R8: A misaligned address (word: `rs1_val[1:0]`≠0; doubleword: `rs1_val[2:0]`≠0) on a legal instruction gives `res_err`=1 and `res_data`=0, makes no memory access and clears the reservation.
- R9: `ins_ready` is low from the accepting edge until the memory response has been taken. `mem_req` is a one-cycle pulse, and an instruction offered while `ins_ready` is low is ignored.
- R10: `mem_aq` and `mem_rl` carry the instruction's aq and rl bits while `mem_req` is high.
- R11: After reset `ins_ready`=1, `res_valid`=0, `mem_req`=0 and no reservation is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit idle, instruction taken when valid |
| ins_word | input | 32 | Instruction encoding |
| rs1_val | input | 64 | Address operand |
| rs2_val | input | 64 | Store data operand |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_dbl | output | 1 | Request is 64-bit (else 32-bit) |
| mem_aq | output | 1 | Acquire bit forwarded |
| mem_rl | output | 1 | Release bit forwarded |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data, word in low half |
| mem_rsp_valid | input | 1 | Memory response, at least one cycle after the request |
| mem_rdata | input | 64 | Read data, word in low half |
| snoop_valid | input | 1 | Write by another agent observed |
| snoop_addr | input | 64 | Address of that write |
| res_valid | output | 1 | Result pulse |
| res_rd | output | 5 | Destination register index |
| res_data | output | 64 | Value for the destination register |
| res_err | output | 1 | Misaligned address |
| res_ill | output | 1 | Illegal encoding |

## Verification
A sequence of vectors runs alternating reservations and conditional stores against one memory image. The sequence tells apart a granule-sharing word pair from a neighbouring granule, a replaced reservation from the original, and a failed store from a successful one: a later read shows whether memory changed. Directed cases place snoops during an outstanding load, on the same edge as the conditional store, and to a foreign granule. These separate the clearing path from the same-cycle priority. Misaligned, illegal and busy-time instructions are each followed by a conditional store whose outcome exposes whether the reservation survived. The bench also counts memory requests to prove that no access was made.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [4:0] FN_LOADRES = 5'b00010;
  localparam logic [4:0] FN_STORECOND = 5'b00011;
  localparam logic [2:0] WD_WORD = 3'b010;
  localparam logic [2:0] WD_DWORD = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_st_e;

  typedef struct packed {
    logic       legal;
    logic       is_lr;
    logic       is_sc;
    logic       dbl;
    logic       aq;
    logic       rl;
    logic [4:0] rd;
  } op_dec_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
(
  input  logic [31:0] ins_word,
  input  logic [2:0]  addr_lo,
  output op_dec_t     dec,
  output logic        misal
);

  logic [4:0] fn5;
  logic [4:0] rs2_idx;
  logic [2:0] fn3;
  logic [6:0] opc;
  logic       opc_ok;
  logic       width_ok;
  logic       lr_ok;
  logic       sc_ok;

  always_comb begin
    fn5      = ins_word[31:27];
    rs2_idx  = ins_word[24:20];
    fn3      = ins_word[14:12];
    opc      = ins_word[6:0];
    opc_ok   = (opc == OPC_ATOMIC);
    width_ok = (fn3 == WD_WORD) || (fn3 == WD_DWORD);
    lr_ok    = (fn5 == FN_LOADRES) && (rs2_idx == 5'd0);
    sc_ok    = (fn5 == FN_STORECOND);

    dec.legal = opc_ok && width_ok && (lr_ok || sc_ok);
    dec.is_lr = lr_ok;
    dec.is_sc = sc_ok;
    dec.dbl   = (fn3 == WD_DWORD);
    dec.aq    = ins_word[26];
    dec.rl    = ins_word[25];
    dec.rd    = ins_word[11:7];

    if (dec.dbl) begin
      misal = |addr_lo[2:0];
    end else begin
      misal = |addr_lo[1:0];
    end
  end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int XLEN       = 64,
  parameter int GRAN_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_en,
  input  logic [XLEN-1:0]              set_addr,
  input  logic                         clr_en,
  input  logic                         snp_valid,
  input  logic [XLEN-1:0]              snp_addr,
  input  logic [XLEN-1:0]              chk_addr,
  output logic                         chk_hit,
  output logic                         resv_valid,
  output logic [XLEN-$clog2(GRAN_BYTES)-1:0] resv_gran
);

  localparam int GL = $clog2(GRAN_BYTES);
  localparam int GW = XLEN - GL;

  logic          valid_q;
  logic          valid_n;
  logic [GW-1:0] gran_q;
  logic          snp_hit;

  always_comb begin
    snp_hit = snp_valid && valid_q && (snp_addr[XLEN-1:GL] == gran_q);
    chk_hit = valid_q && !snp_hit && (chk_addr[XLEN-1:GL] == gran_q);

    valid_n = valid_q;
    if (set_en) begin
      valid_n = 1'b1;
    end else if (clr_en || snp_hit) begin
      valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gran_q  <= '0;
    end else begin
      valid_q <= valid_n;
      if (set_en) begin
        gran_q <= set_addr[XLEN-1:GL];
      end
    end
  end

  assign resv_valid = valid_q;
  assign resv_gran  = gran_q;

endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  op_dec_t         dec,
  input  logic            misal,
  input  logic [XLEN-1:0] op_addr,
  input  logic [XLEN-1:0] op_wdata,
  input  logic            resv_hit,
  output logic            ins_ready,
  output logic            fire,
  output logic            resv_set,
  output logic            resv_clr,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_dbl,
  output logic            mem_aq,
  output logic            mem_rl,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            res_valid,
  output logic [4:0]      res_rd,
  output logic [XLEN-1:0] res_data,
  output logic            res_err,
  output logic            res_ill
);

  localparam int UPPER = XLEN - WORD;

  seq_st_e         st_q, st_n;
  logic            ld_req;
  logic            we_q, dbl_q, aq_q, rl_q, lr_q;
  logic [4:0]      rd_q;
  logic [XLEN-1:0] addr_q, wd_q;
  logic [XLEN-1:0] wd_n;
  logic [XLEN-1:0] load_ext;

  logic            rv_n, err_n, ill_n;
  logic [4:0]      rrd_n;
  logic [XLEN-1:0] rdat_n;
  logic            rv_q, err_q, ill_q;
  logic [4:0]      rrd_q;
  logic [XLEN-1:0] rdat_q;

  always_comb begin
    if (dbl_q) begin
      load_ext = mem_rdata;
    end else begin
      load_ext = {{UPPER{mem_rdata[WORD-1]}}, mem_rdata[WORD-1:0]};
    end
    if (dec.dbl) begin
      wd_n = op_wdata;
    end else begin
      wd_n = {{UPPER{1'b0}}, op_wdata[WORD-1:0]};
    end
  end

  always_comb begin
    st_n     = st_q;
    fire     = ins_valid && (st_q == ST_IDLE);
    ld_req   = 1'b0;
    resv_set = 1'b0;
    resv_clr = 1'b0;
    rv_n     = 1'b0;
    err_n    = 1'b0;
    ill_n    = 1'b0;
    rrd_n    = dec.rd;
    rdat_n   = '0;

    unique case (st_q)
      ST_IDLE: begin
        if (fire) begin
          if (!dec.legal) begin
            rv_n  = 1'b1;
            ill_n = 1'b1;
          end else if (misal) begin
            rv_n     = 1'b1;
            err_n    = 1'b1;
            resv_clr = 1'b1;
          end else if (dec.is_lr) begin
            resv_set = 1'b1;
            ld_req   = 1'b1;
            st_n     = ST_ISSUE;
          end else begin
            resv_clr = 1'b1;
            if (resv_hit) begin
              ld_req = 1'b1;
              st_n   = ST_ISSUE;
            end else begin
              rv_n   = 1'b1;
              rdat_n = {{(XLEN-1){1'b0}}, 1'b1};
            end
          end
        end
      end
      ST_ISSUE: begin
        st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          st_n  = ST_IDLE;
          rv_n  = 1'b1;
          rrd_n = rd_q;
          if (lr_q) begin
            rdat_n = load_ext;
          end
        end
      end
      default: begin
        st_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      we_q   <= 1'b0;
      dbl_q  <= 1'b0;
      aq_q   <= 1'b0;
      rl_q   <= 1'b0;
      lr_q   <= 1'b0;
      rd_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rv_q   <= 1'b0;
      err_q  <= 1'b0;
      ill_q  <= 1'b0;
      rrd_q  <= '0;
      rdat_q <= '0;
    end else begin
      st_q <= st_n;
      rv_q <= rv_n;
      if (ld_req) begin
        we_q   <= dec.is_sc;
        dbl_q  <= dec.dbl;
        aq_q   <= dec.aq;
        rl_q   <= dec.rl;
        lr_q   <= dec.is_lr;
        rd_q   <= dec.rd;
        addr_q <= op_addr;
        wd_q   <= wd_n;
      end
      if (rv_n) begin
        err_q  <= err_n;
        ill_q  <= ill_n;
        rrd_q  <= rrd_n;
        rdat_q <= rdat_n;
      end
    end
  end

  assign ins_ready = (st_q == ST_IDLE);
  assign mem_req   = (st_q == ST_ISSUE);
  assign mem_we    = we_q;
  assign mem_dbl   = dbl_q;
  assign mem_aq    = aq_q;
  assign mem_rl    = rl_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign res_valid = rv_q;
  assign res_rd    = rrd_q;
  assign res_data  = rdat_q;
  assign res_err   = err_q;
  assign res_ill   = ill_q;

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
  import lrsc_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int GRAN_BYTES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [31:0]     ins_word,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_dbl,
  output logic            mem_aq,
  output logic            mem_rl,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            snoop_valid,
  input  logic [XLEN-1:0] snoop_addr,
  output logic            res_valid,
  output logic [4:0]      res_rd,
  output logic [XLEN-1:0] res_data,
  output logic            res_err,
  output logic            res_ill
);

  localparam int GL = $clog2(GRAN_BYTES);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_s_n;
  op_dec_t                dec;
  logic                   misal;
  logic                   fire;
  logic                   resv_set;
  logic                   resv_clr;
  logic                   resv_hit;
  logic                   resv_valid;
  logic [XLEN-GL-1:0]     resv_gran;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= 1'b0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_s_n = rst_pipe[SYNC_STAGES-1];

  lrsc_decode u_dec (
    .ins_word (ins_word),
    .addr_lo  (rs1_val[2:0]),
    .dec      (dec),
    .misal    (misal)
  );

  lrsc_resv #(.XLEN(XLEN), .GRAN_BYTES(GRAN_BYTES)) u_resv (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .set_en     (resv_set),
    .set_addr   (rs1_val),
    .clr_en     (resv_clr),
    .snp_valid  (snoop_valid),
    .snp_addr   (snoop_addr),
    .chk_addr   (rs1_val),
    .chk_hit    (resv_hit),
    .resv_valid (resv_valid),
    .resv_gran  (resv_gran)
  );

  lrsc_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .ins_valid     (ins_valid),
    .dec           (dec),
    .misal         (misal),
    .op_addr       (rs1_val),
    .op_wdata      (rs2_val),
    .resv_hit      (resv_hit),
    .ins_ready     (ins_ready),
    .fire          (fire),
    .resv_set      (resv_set),
    .resv_clr      (resv_clr),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_dbl       (mem_dbl),
    .mem_aq        (mem_aq),
    .mem_rl        (mem_rl),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rdata     (mem_rdata),
    .res_valid     (res_valid),
    .res_rd        (res_rd),
    .res_data      (res_data),
    .res_err       (res_err),
    .res_ill       (res_ill)
  );

endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
  parameter int XLEN = 64,
  parameter int GL   = 3
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic               ins_valid,
  input logic               ins_ready,
  input logic               fire,
  input logic               is_sc,
  input logic               legal,
  input logic               misal,
  input logic               mem_req,
  input logic               mem_rsp_valid,
  input logic               snoop_valid,
  input logic [XLEN-1:0]    snoop_addr,
  input logic               resv_set,
  input logic               resv_valid,
  input logic [XLEN-GL-1:0] resv_gran,
  input logic               res_valid,
  input logic [XLEN-1:0]    res_data,
  input logic               res_err,
  input logic               res_ill
);

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req |=> !mem_req); // R9

  AST_BUSY_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req |-> !ins_ready); // R9

  AST_ACCEPT_OUTCOME: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ins_valid && ins_ready) |=> (mem_req ^ res_valid)); // R5

  AST_RSP_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_rsp_valid && !ins_ready && !mem_req) |=> res_valid); // R2

  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fire && legal && is_sc) |=> !resv_valid); // R6

  AST_MISAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fire && legal && misal) |=> (!resv_valid && res_err)); // R8

  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (snoop_valid && resv_valid && !resv_set &&
     (snoop_addr[XLEN-1:GL] == resv_gran)) |=> !resv_valid); // R7

  AST_FLAG_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_s_n)
    (res_valid && (res_err || res_ill)) |-> (res_data == '0)); // R1

endmodule

bind lrsc_unit lrsc_unit_chk #(.XLEN(XLEN), .GL(GL)) u_chk (
  .clk           (clk),
  .rst_s_n       (rst_s_n),
  .ins_valid     (ins_valid),
  .ins_ready     (ins_ready),
  .fire          (fire),
  .is_sc         (dec.is_sc),
  .legal         (dec.legal),
  .misal         (misal),
  .mem_req       (mem_req),
  .mem_rsp_valid (mem_rsp_valid),
  .snoop_valid   (snoop_valid),
  .snoop_addr    (snoop_addr),
  .resv_set      (resv_set),
  .resv_valid    (resv_valid),
  .resv_gran     (resv_gran),
  .res_valid     (res_valid),
  .res_data      (res_data),
  .res_err       (res_err),
  .res_ill       (res_ill)
);

// File: tb/lrsc_unit_bench.sv
module lrsc_unit_bench;

  localparam int CLK_P = 10;
  localparam int LAT   = 2;

  logic        clk;
  logic        rst_n;
  logic        ins_valid;
  logic        ins_ready;
  logic [31:0] ins_word;
  logic [63:0] rs1_val;
  logic [63:0] rs2_val;
  logic        mem_req, mem_we, mem_dbl, mem_aq, mem_rl;
  logic [63:0] mem_addr, mem_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rdata;
  logic        snoop_valid;
  logic [63:0] snoop_addr;
  logic        res_valid;
  logic [4:0]  res_rd;
  logic [63:0] res_data;
  logic        res_err, res_ill;

  int n_tests = 0;
  int n_fail  = 0;
  int n_req   = 0;
  logic cap_aq, cap_rl;

  lrsc_unit u_lrsc_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .mem_req(mem_req), .mem_we(mem_we), .mem_dbl(mem_dbl), .mem_aq(mem_aq),
    .mem_rl(mem_rl), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .res_valid(res_valid), .res_rd(res_rd), .res_data(res_data),
    .res_err(res_err), .res_ill(res_ill)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // memory model: 16 doublewords, word lanes picked by address bit 2
  logic [63:0] mem [16];
  int          cnt = 0;
  logic [63:0] pend_rd;

  function automatic logic [63:0] orig(input int i);
    return {32'h1234_5600 + 32'(i), 32'h8765_4300 + 32'(i)};
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rdata     <= pend_rd;
      end
    end else if (mem_req) begin
      n_req++;
      cap_aq = mem_aq;
      cap_rl = mem_rl;
      if (mem_we) begin
        if (mem_dbl)          mem[mem_addr[6:3]] = mem_wdata;
        else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] = mem_wdata[31:0];
        else                  mem[mem_addr[6:3]][31:0]  = mem_wdata[31:0];
        pend_rd = '0;
      end else if (mem_dbl) begin
        pend_rd = mem[mem_addr[6:3]];
      end else begin
        pend_rd = {32'hDEAD_BEEF,
                   mem_addr[2] ? mem[mem_addr[6:3]][63:32] : mem[mem_addr[6:3]][31:0]};
      end
      cnt <= LAT;
    end
  end

  function automatic logic [31:0] enc(input logic [4:0] f5, input logic aq,
                                      input logic rl, input logic [4:0] rs2,
                                      input logic [2:0] f3, input logic [4:0] rd);
    return {f5, aq, rl, rs2, 5'd10, f3, rd, 7'b0101111};
  endfunction

  function automatic logic [31:0] lr_w(input logic dbl);
    return enc(5'b00010, 1'b0, 1'b0, 5'd0, dbl ? 3'b011 : 3'b010, 5'd7);
  endfunction

  function automatic logic [31:0] sc_w(input logic dbl);
    return enc(5'b00011, 1'b0, 1'b0, 5'd12, dbl ? 3'b011 : 3'b010, 5'd9);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [31:0] w, input logic [63:0] a, input logic [63:0] d);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_word  = w;
    rs1_val   = a;
    rs2_val   = d;
  endtask

  logic [63:0] got_d;
  logic        got_e, got_i;

  task automatic wait_res();
    got_d = 'x; got_e = 1'bx; got_i = 1'bx;
    for (int k = 0; k < 40; k++) begin
      if (res_valid) begin
        got_d = res_data; got_e = res_err; got_i = res_ill;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic [63:0] a, input logic [63:0] d);
    start(w, a, d);
    @(negedge clk);
    ins_valid = 1'b0;
    wait_res();
    @(negedge clk);
  endtask

  typedef struct packed {
    logic        sc;
    logic        dbl;
    logic [63:0] addr;
    logic [63:0] wd;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b0, 1'b0, 64'h10, 64'h0, 64'hFFFF_FFFF_8765_4302},              // R2 sign ext
    '{1'b1, 1'b0, 64'h14, 64'h0000_0000_AAAA_5555, 64'h0},              // R4 same granule
    '{1'b0, 1'b0, 64'h14, 64'h0, 64'hFFFF_FFFF_AAAA_5555},
    '{1'b1, 1'b1, 64'h10, 64'h0123_4567_89AB_CDEF, 64'h0},
    '{1'b1, 1'b1, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1},              // R6 cleared
    '{1'b0, 1'b1, 64'h10, 64'h0, 64'h0123_4567_89AB_CDEF},              // R5 no write
    '{1'b1, 1'b0, 64'h18, 64'h5, 64'h1},                                // other granule
    '{1'b0, 1'b1, 64'h18, 64'h0, 64'h1234_5603_8765_4303},
    '{1'b0, 1'b0, 64'h20, 64'h0, 64'hFFFF_FFFF_8765_4304},              // R3 replace
    '{1'b1, 1'b0, 64'h18, 64'h1, 64'h1},
    '{1'b0, 1'b0, 64'h1C, 64'h0, 64'h0000_0000_1234_5603},
    '{1'b1, 1'b0, 64'h1C, 64'h7000_0001, 64'h0},
    '{1'b0, 1'b0, 64'h1C, 64'h0, 64'h0000_0000_7000_0001}
  };

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r0;
    for (int i = 0; i < 16; i++) mem[i] = orig(i);
    rst_n = 1'b0; ins_valid = 1'b0; ins_word = '0; rs1_val = '0; rs2_val = '0;
    snoop_valid = 1'b0; snoop_addr = '0; mem_rsp_valid = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check("R11 ready", {63'd0, ins_ready}, 64'd1);
    check("R11 res_valid", {63'd0, res_valid}, 64'd0);
    check("R11 mem_req", {63'd0, mem_req}, 64'd0);
    r0 = n_req;
    run(sc_w(1'b0), 64'h0, 64'h9);
    check("R11 no reservation", got_d, 64'h1);
    check("R11 no request", 64'(n_req - r0), 64'd0);

    // vector table
    for (int v = 0; v < 13; v++) begin
      r0 = n_req;
      run(VECS[v].sc ? sc_w(VECS[v].dbl) : lr_w(VECS[v].dbl), VECS[v].addr, VECS[v].wd);
      if (!VECS[v].sc)           check("R2 load value", got_d, VECS[v].exp);
      else if (VECS[v].exp == 0) check("R4 sc success", got_d, VECS[v].exp);
      else begin
        check("R5 sc fail value", got_d, VECS[v].exp);
        check("R5 sc fail no request", 64'(n_req - r0), 64'd0);
      end
    end

    // R7 snoop to same granule while load outstanding
    start(lr_w(1'b0), 64'h28, 64'h0);
    @(negedge clk);
    ins_valid = 1'b0; snoop_valid = 1'b1; snoop_addr = 64'h2C;
    @(negedge clk);
    snoop_valid = 1'b0;
    wait_res();
    @(negedge clk);
    run(sc_w(1'b0), 64'h28, 64'h3);
    check("R7 snoop hit clears", got_d, 64'h1);

    // R7 snoop to another granule
    start(lr_w(1'b0), 64'h30, 64'h0);
    @(negedge clk);
    ins_valid = 1'b0; snoop_valid = 1'b1; snoop_addr = 64'h38;
    @(negedge clk);
    snoop_valid = 1'b0;
    wait_res();
    @(negedge clk);
    run(sc_w(1'b0), 64'h30, 64'h11);
    check("R7 foreign snoop ignored", got_d, 64'h0);

    // R7 snoop on the same edge as the store-conditional
    run(lr_w(1'b1), 64'h40, 64'h0);
    r0 = n_req;
    start(sc_w(1'b1), 64'h40, 64'h5555);
    snoop_valid = 1'b1; snoop_addr = 64'h44;
    @(negedge clk);
    ins_valid = 1'b0; snoop_valid = 1'b0;
    wait_res();
    @(negedge clk);
    check("R7 same-cycle snoop wins", got_d, 64'h1);
    check("R7 same-cycle no request", 64'(n_req - r0), 64'd0);
    run(lr_w(1'b1), 64'h40, 64'h0);
    check("R7 memory unchanged", got_d, orig(8));

    // R8 misaligned
    run(lr_w(1'b0), 64'h50, 64'h0);
    r0 = n_req;
    run(sc_w(1'b0), 64'h52, 64'h1);
    check("R8 misaligned err", {63'd0, got_e}, 64'd1);
    check("R8 misaligned data", got_d, 64'h0);
    check("R8 no access", 64'(n_req - r0), 64'd0);
    run(sc_w(1'b0), 64'h50, 64'h1);
    check("R8 reservation cleared", got_d, 64'h1);
    r0 = n_req;
    run(lr_w(1'b1), 64'h54, 64'h0);
    check("R8 dword misaligned", {63'd0, got_e}, 64'd1);
    check("R8 dword no access", 64'(n_req - r0), 64'd0);

    // R1 illegal encodings
    r0 = n_req;
    run(enc(5'b00010, 1'b0, 1'b0, 5'd3, 3'b010, 5'd4), 64'h60, 64'h0);
    check("R1 lr rs2 nonzero", {63'd0, got_i}, 64'd1);
    run(enc(5'b00011, 1'b0, 1'b0, 5'd3, 3'b000, 5'd4), 64'h60, 64'h0);
    check("R1 bad width", {63'd0, got_i}, 64'd1);
    run(enc(5'b00001, 1'b0, 1'b0, 5'd3, 3'b010, 5'd4), 64'h60, 64'h0);
    check("R1 other funct5", {63'd0, got_i}, 64'd1);
    check("R1 no access", 64'(n_req - r0), 64'd0);

    // R10 ordering bits
    run(enc(5'b00010, 1'b1, 1'b0, 5'd0, 3'b010, 5'd4), 64'h60, 64'h0);
    check("R10 aq on load", {62'd0, cap_aq, cap_rl}, 64'b10);
    run(enc(5'b00011, 1'b0, 1'b1, 5'd2, 3'b010, 5'd4), 64'h60, 64'h77);
    check("R10 rl on store", {62'd0, cap_aq, cap_rl}, 64'b01);

    // R9 instruction offered while busy is dropped
    start(lr_w(1'b0), 64'h68, 64'h0);
    @(negedge clk);
    ins_word = sc_w(1'b0); rs1_val = 64'h68; rs2_val = 64'h42;
    check("R9 ready low while busy", {63'd0, ins_ready}, 64'd0);
    @(negedge clk);
    ins_valid = 1'b0;
    wait_res();
    check("R9 load result", got_d, 64'hFFFF_FFFF_8765_430D);
    r0 = n_req;
    repeat (4) begin
      @(negedge clk);
      check("R9 no extra result", {63'd0, res_valid}, 64'd0);
    end
    check("R9 dropped no request", 64'(n_req - r0), 64'd0);
    run(sc_w(1'b0), 64'h68, 64'h42);
    check("R9 reservation intact", got_d, 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule